// File: doc/BRIEF.md
# Glitch-free clock selector

This block picks one of up to four asynchronous input clocks and drives it onto a single output clock. A binary select value chooses the source at run time. In the glitch-free build the change of source never produces a shortened high or low phase. Each input has its own enable chain, which updates on that input's falling edge. A small sequencer, running on input 0, shuts off the enable of the old source. It releases the new source only after it has seen every enable low.

The sequencer needs input 0 to run in order to take a select value. A switch completes only if the old source is still toggling. If the old source has stopped, the output stays parked on it. A build parameter removes all of this and leaves a plain combinational multiplexer. The number of inputs is 1 to 4. The select width is 1 or 2 bits.

Top module: `clk_mux_gf`

## Requirements
- R1: After reset is released with select value 0, the output toggles at the rate of input 0.
- R2: In the glitch-free build, select value k (binary: 0 = input 0, 1 = input 1, 2 = input 2, 3 = input 3) moves the output onto input k once the switch sequence completes. At most one input's enable is active at any time.
- R3: No high or low phase of the output is shorter than the shortest half period among the input clocks, including across a switch.
- R4: If the current source is stopped when a new value is selected, the output stays parked on the stopped source and no edge of the new source reaches it. Once the old source runs again, the switch completes.
- R5: A select change made while input 0 is stopped has no effect. It takes effect after input 0 restarts.
- R6: In the glitch-free build, a select value at or above the input count is ignored, and the current source is kept.
- R7: With the glitch-free parameter off (the default), the output equals the selected input at once. A select value at or above the input count gives a low output.
- R8: While the asynchronous active-low reset is low, the output follows input 0 and every other enable is clear, whatever source was active before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | N_IN | Input clocks, bit k is source k |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | SEL_W | Binary index of the wanted source |
| clk_o | output | 1 | Selected output clock |

## Verification
If the enable state goes wrong, the output shows it within a few cycles of the slower clock involved. A runt or overlapping phase appears at the first switch. An output edge rate that matches the wrong input appears as soon as the switch should have settled. If a stopped source releases the new clock too early, edges appear where the output should stay flat. If a select value is taken while input 0 is stopped, the new rate appears early. The bench measures every output phase and counts output edges over fixed windows, so each of these shows up within one window.

// File: rtl/clk_mux_pkg.sv
`timescale 1ns/1ps
package clk_mux_pkg;
  localparam int MAX_IN = 4;
endpackage

// File: rtl/clk_mux_sel_sync.sv
`timescale 1ns/1ps
// Select sequencer in the input-0 domain: drops the old request and waits
// until every lane enable reads low before raising the new one.
module clk_mux_sel_sync #(
  parameter int N_IN  = 4,
  parameter int SEL_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_IN-1:0]  en_i,
  output logic [N_IN-1:0]  req_o
);
  localparam logic [N_IN-1:0] IDX0 = N_IN'(1);

  logic [SEL_W-1:0] sel_m, sel_s;
  logic [N_IN-1:0]  en_m, en_s, tgt, sel_oh;
  logic             sel_take;

  always_comb begin
    for (int k = 0; k < N_IN; k++) sel_oh[k] = (int'(sel_s) == k);
    sel_take = (sel_s == sel_m) && (|sel_oh) && (sel_oh != tgt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_m <= '0;
      sel_s <= '0;
      en_m  <= IDX0;
      en_s  <= IDX0;
      tgt   <= IDX0;
      req_o <= IDX0;
    end else begin
      sel_m <= sel_i;
      sel_s <= sel_m;
      en_m  <= en_i;
      en_s  <= en_m;
      if (req_o == tgt) begin
        // accept only after the previous switch is seen complete
        if (en_s == tgt && sel_take) begin
          tgt   <= sel_oh;
          req_o <= '0;
        end
      end else if (en_s == '0) begin
        req_o <= tgt;
      end
    end
  end

  p_req_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o));
  p_req_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o != '0 && req_o != $past(req_o)) |-> $past(req_o) == '0);
  p_park_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o == '0 && en_s != '0) |=> req_o == '0);
endmodule

// File: rtl/clk_mux_lane.sv
`timescale 1ns/1ps
// Per-input enable chain, two flops on the falling edge of its own clock.
module clk_mux_lane #(
  parameter bit RST_EN = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic others_off_i,
  output logic en_o,
  output logic gclk_o
);
  logic s1;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1   <= RST_EN;
      en_o <= RST_EN;
    end else begin
      s1   <= req_i & others_off_i;
      en_o <= s1;
    end
  end

  // enable changes only while clk_i is low
  assign gclk_o = clk_i & en_o;

  p_en_rise_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> ($past(req_i, 2) && $past(others_off_i, 2)));
endmodule

// File: rtl/clk_mux_gf.sv
`timescale 1ns/1ps
module clk_mux_gf
  import clk_mux_pkg::*;
#(
  parameter int N_IN        = 4,
  parameter int SEL_W       = 1,
  parameter bit GLITCH_FREE = 1'b0
) (
  input  logic [N_IN-1:0]  clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_o
);
  initial begin
    if (N_IN < 1 || N_IN > MAX_IN) $error("N_IN out of range");
    if (SEL_W < 1 || SEL_W > 2)    $error("SEL_W out of range");
  end

  if (GLITCH_FREE) begin : g_gf
    logic [N_IN-1:0] en, gclk, req, others_off;

    clk_mux_sel_sync #(.N_IN(N_IN), .SEL_W(SEL_W)) u_sel (
      .clk_i  (clk_i[0]),
      .rst_ni (rst_ni),
      .sel_i  (sel_i),
      .en_i   (en),
      .req_o  (req)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_lane
      localparam logic [N_IN-1:0] OWN = N_IN'(1) << g;
      assign others_off[g] = ~|(en & ~OWN);

      clk_mux_lane #(.RST_EN(g == 0)) u_lane (
        .clk_i        (clk_i[g]),
        .rst_ni       (rst_ni),
        .req_i        (req[g]),
        .others_off_i (others_off[g]),
        .en_o         (en[g]),
        .gclk_o       (gclk[g])
      );

      p_onehot_en_r2: assert property (@(posedge clk_i[g]) disable iff (!rst_ni)
        $onehot0(en));
    end

    assign clk_o = |gclk;
  end else begin : g_comb
    logic [MAX_IN-1:0] clk_ext;
    logic              unused_rst;
    assign unused_rst = rst_ni;
    always_comb begin
      clk_ext = '0;
      clk_ext[N_IN-1:0] = clk_i;
    end
    assign clk_o = clk_ext[sel_i];
  end
endmodule

// File: tb/clk_mux_gf_tb.sv
`timescale 1ns/1ps
module clk_mux_gf_tb;
  localparam int HALF[4] = '{5, 7, 11, 17};
  localparam int WIN = 680;

  logic tb_clk = 1'b0;
  always #4 tb_clk = ~tb_clk;

  logic c0 = 0, c1 = 0, c2 = 0, c3 = 0;
  logic [3:0] run = 4'hf;
  logic [3:0] c;
  assign c = {c3, c2, c1, c0};
  initial forever begin #(HALF[0]); if (run[0] || c0) c0 = ~c0; end
  initial forever begin #(HALF[1]); if (run[1] || c1) c1 = ~c1; end
  initial forever begin #(HALF[2]); if (run[2] || c2) c2 = ~c2; end
  initial forever begin #(HALF[3]); if (run[3] || c3) c3 = ~c3; end

  logic       rst_n = 1'b0;
  logic [1:0] sel_a = 2'd0, sel_b = 2'd0;
  logic       out_a, out_b, out_m;

  clk_mux_gf #(.N_IN(4), .SEL_W(2), .GLITCH_FREE(1'b1)) u_dut (
    .clk_i(c), .rst_ni(rst_n), .sel_i(sel_a), .clk_o(out_a));
  clk_mux_gf #(.N_IN(3), .SEL_W(2), .GLITCH_FREE(1'b1)) u_dut3 (
    .clk_i(c[2:0]), .rst_ni(rst_n), .sel_i(sel_b), .clk_o(out_b));
  clk_mux_gf #(.N_IN(3), .SEL_W(2), .GLITCH_FREE(1'b0)) u_mux (
    .clk_i(c[2:0]), .rst_ni(rst_n), .sel_i(sel_b), .clk_o(out_m));

  int checks = 0, fails = 0;
  bit done = 0;
  int cnt_a = 0, cnt_b = 0;
  always @(posedge out_a) cnt_a++;
  always @(posedge out_b) cnt_b++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_edges(input int idx);
    return (idx < 0) ? 0 : WIN / (2 * HALF[idx]);
  endfunction

  // R3: phase monitor on the 4-input instance
  realtime last = -1.0;
  always @(out_a) begin
    if (!rst_n) last = -1.0;
    else begin
      if (last >= 0.0) begin
        checks++;
        if ($realtime - last < 4.99) begin
          fails++;
          $display("FAIL R3: phase actual %0.3f ns expected >= 5.000 ns",
                   $realtime - last);
        end
      end
      last = $realtime;
    end
  end

  // settle (when asked), then count rising output edges over WIN
  task automatic src(input bit on_b, input int idx, input bit settle,
                     input string tag);
    int s, n, e;
    if (settle) #700;
    s = on_b ? cnt_b : cnt_a;
    #(WIN);
    n = (on_b ? cnt_b : cnt_a) - s;
    e = exp_edges(idx);
    chk((e == 0) ? (n == 0) : (n >= e - 1 && n <= e + 1), tag, n, e);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // R7: combinational build compared at mid-phase sample points
  initial begin
    #0.5;
    forever begin
      #3;
      if (rst_n) chk(out_m == ((sel_b < 3) ? c[sel_b] : 1'b0), "R7",
                     int'(out_m), int'((sel_b < 3) ? c[sel_b] : 1'b0));
    end
  end

  initial begin
    int s;
    void'($urandom(32'd1234));
    #53 rst_n = 1'b1;
    src(0, 0, 1, "R1");
    src(1, 0, 0, "R1");

    // directed walk through every code
    for (int k = 1; k < 4; k++) begin
      sel_a = 2'(k);
      src(0, k, 1, "R2");
    end
    sel_a = 2'd0;
    src(0, 0, 1, "R2");

    // 3-input instance, unused index
    sel_b = 2'd1;
    src(1, 1, 1, "R2");
    sel_b = 2'd3;
    src(1, 1, 1, "R6");
    sel_b = 2'd2;
    src(1, 2, 1, "R2");
    sel_b = 2'd3;
    src(1, 2, 1, "R6");

    // random select sequence
    for (int i = 0; i < 10; i++) begin
      s = int'($urandom % 4);
      sel_a = 2'(s);
      src(0, s, 1, "R2");
    end

    // old source stopped: output parked
    sel_a = 2'd2;
    src(0, 2, 1, "R4");
    run[2] = 1'b0;
    #100 sel_a = 2'd1;
    #1000;
    src(0, -1, 0, "R4");
    run[2] = 1'b1;
    src(0, 1, 1, "R4");

    // input 0 stopped: select not sampled
    run[0] = 1'b0;
    #50 sel_a = 2'd3;
    src(0, 1, 1, "R5");
    run[0] = 1'b1;
    src(0, 3, 1, "R5");

    // reset mid-operation
    rst_n = 1'b0;
    #50;
    src(0, 0, 0, "R8");
    src(1, 0, 0, "R8");
    sel_a = 2'd0;
    sel_b = 2'd0;
    #40 rst_n = 1'b1;
    src(0, 0, 1, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule